// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block is the arithmetic stage of a 64-bit media datapath. Each operand word is viewed either as eight unsigned byte lanes or as four signed halfword lanes. The same 4-bit operation is applied to every lane in the same cycle. The operations cover bitwise logic, logical and arithmetic shifts, saturating add, subtract and multiply, signed or unsigned min and max, a halfword sign-transfer, and a byte rounding average and absolute difference.

The first operand is always a full vector. The second operand comes from one of three sources, chosen by a 5-bit format/select word:
- the whole second vector;
- one lane of the second vector, copied into every lane;
- a 5-bit immediate, zero-extended and copied into every lane.

Inputs are taken on a valid strobe. The result appears in a register one clock later, together with a valid flag. Any operation that is not defined for the chosen lane format gives a zero result and raises an illegal-operation flag for that one result.

Top module: `simd_lane_alu`

## Requirements
- R1: While synchronous active-high reset is asserted, and on the first clock after it, `out_valid`, `illegal` and `result` are all zero.
- R2: A request accepted with `in_valid` high at clock edge k appears on `result` and `out_valid` right after edge k. When `in_valid` is low, `out_valid` and `illegal` go low and `result` keeps its last value.
- R3: `fmt_sel[0]` selects the lane format: 0 gives eight unsigned 8-bit lanes, 1 gives four signed 16-bit lanes. Lane 0 is in the least significant bits. The second operand source is set by the upper select bits:
  - `fmt_sel[4]`=0: one lane of `vec_b` is copied to every lane. The lane index is `fmt_sel[3:1]` for bytes and `fmt_sel[3:2]` for halfwords.
  - `fmt_sel[4:3]`=10: the full `vec_b` is used.
  - `fmt_sel[4:3]`=11: `imm`, zero-extended, is copied to every lane.
- R4: Opcode encoding: 0 and, 1 nor, 2 or, 3 xor, 4 shift left logical, 5 shift right logical, 6 add, 7 sub, 8 min, 9 max, 10 mul, 11 sign-transfer, 12 shift right arithmetic, 13 absolute difference, 14 average, 15 reserved. The four logic opcodes act bitwise in both formats.
- R5: Shift counts are the low 3 bits of the second operand lane for bytes and the low 4 bits for halfwords. The arithmetic right shift exists only for halfwords and replicates the sign bit.
- R6: Byte add and mul clamp to 255. A byte subtract that would go below zero gives 0.
- R7: Halfword add, sub and mul clamp to the range -32768..32767.
- R8: Min and max compare unsigned for bytes and signed for halfwords.
- R9: Halfword sign-transfer gives one of three results:
  - when the first lane is negative, the negated second lane, with -32768 giving 32767;
  - when the first lane is zero, 0;
  - otherwise, the second lane unchanged.
- R10: Byte average is (a+b+1)>>1 with no lost carry. Byte absolute difference is |a-b|.
- R11: Opcodes 11 and 12 for bytes, 13 and 14 for halfwords, and 15 in both formats are illegal. They give a zero `result` and set `illegal` for that single result only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is high |
| fmt_sel | input | 5 | Lane format (bit 0) and second-operand source/lane index |
| opcode | input | 4 | Lane operation |
| vec_a | input | 64 | First operand vector |
| vec_b | input | 64 | Second operand vector |
| imm | input | 5 | Immediate value broadcast in immediate mode |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 64 | Registered result vector |
| illegal | output | 1 | Opcode was not defined for the chosen format |

## Verification
The bench goes after the saturation edges, where a design that drops the carry or overflow bits wraps:
- byte 200+100 must give 255;
- halfword 30000+10000 must give 32767;
- 300*300 must give 32767.

It also checks cases that a careless design gets wrong:
- A sign-transfer of -32768 must give 32767; a design without the special case returns the most negative value.
- The byte average 255,255 must give 255; a design that loses the carry gives 127.
- A byte max of 0x80 against 0x7F must give 0x80; a signed compare picks the wrong lane.
- An arithmetic shift must fill with the sign bit.
- A shift count above the lane width must be masked, not shifted out to zero.
- Lane broadcast must fetch the indexed lane; an off-by-one index field broadcasts a neighbour.
- Illegal opcodes must give a zero result, and the flag must drop after that single result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_NOR  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_ADD  = 4'd6,
    OP_SUB  = 4'd7,
    OP_MIN  = 4'd8,
    OP_MAX  = 4'd9,
    OP_MUL  = 4'd10,
    OP_MSGN = 4'd11,
    OP_SRA  = 4'd12,
    OP_ABSD = 4'd13,
    OP_AVG  = 4'd14,
    OP_RSV  = 4'd15
  } lane_op_e;

  typedef enum logic [1:0] {
    SRC_LANE = 2'd0,
    SRC_VEC  = 2'd1,
    SRC_IMM  = 2'd2
  } src_mode_e;

  // Upper two select bits choose the second-operand source.
  function automatic src_mode_e decode_src(input logic [1:0] hi);
    if (!hi[1])     return SRC_LANE;
    else if (!hi[0]) return SRC_VEC;
    else            return SRC_IMM;
  endfunction

endpackage

// File: rtl/simd_opnd_sel.sv
module simd_opnd_sel
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int IMM_W  = 5,
  localparam int LANES = DATA_W / LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  src_mode_e          mode,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  vec,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  opnd
);

  logic [LANE_W-1:0] picked;
  logic [LANE_W-1:0] imm_ext;

  assign picked  = vec[idx*LANE_W +: LANE_W];
  assign imm_ext = LANE_W'(imm);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (mode)
        SRC_VEC: opnd[g*LANE_W +: LANE_W] = vec[g*LANE_W +: LANE_W];
        SRC_IMM: opnd[g*LANE_W +: LANE_W] = imm_ext;
        default: opnd[g*LANE_W +: LANE_W] = picked;
      endcase
    end
  end

endmodule

// File: rtl/simd_byte_lane.sv
module simd_byte_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8,
  localparam int SH_W = $clog2(W)
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         bad
);

  logic [W:0]     sum;
  logic [W:0]     avg_sum;
  logic [2*W-1:0] prod;
  logic [SH_W-1:0] sh;

  assign sum     = {1'b0, a} + {1'b0, b};
  assign avg_sum = sum + (W+1)'(1);
  assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign sh      = b[SH_W-1:0];

  always_comb begin
    bad = 1'b0;
    res = '0;
    unique case (op)
      OP_AND:  res = a & b;
      OP_NOR:  res = ~(a | b);
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << sh;
      OP_SRL:  res = a >> sh;
      OP_ADD:  res = sum[W] ? {W{1'b1}} : sum[W-1:0];
      OP_SUB:  res = (a < b) ? '0 : a - b;
      OP_MIN:  res = (a < b) ? a : b;
      OP_MAX:  res = (a > b) ? a : b;
      OP_MUL:  res = (|prod[2*W-1:W]) ? {W{1'b1}} : prod[W-1:0];
      OP_ABSD: res = (a >= b) ? a - b : b - a;
      OP_AVG:  res = W'(avg_sum >> 1);
      default: begin
        bad = 1'b1;
        res = '0;
      end
    endcase
  end

  // R6: a saturating unsigned subtract never exceeds the minuend
  always_comb begin
    if (op == OP_SUB) begin
      p_sub_floor_r6: assert (res <= a);
    end
  end

  // R10: the average lies between its two inputs
  always_comb begin
    if (op == OP_AVG) begin
      p_avg_between_r10: assert ((res >= a || res >= b) && (res <= a || res <= b));
    end
  end

endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int SH_W = $clog2(W)
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         bad
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0]   sa, sb;
  logic signed [W:0]     ssum, sdiff;
  logic signed [2*W-1:0] sprod;
  logic [W-1:0]          neg_b;
  logic [SH_W-1:0]       sh;
  logic                  mul_ok;

  assign sa     = $signed(a);
  assign sb     = $signed(b);
  assign ssum   = {sa[W-1], sa} + {sb[W-1], sb};
  assign sdiff  = {sa[W-1], sa} - {sb[W-1], sb};
  assign sprod  = sa * sb;
  assign sh     = b[SH_W-1:0];
  assign neg_b  = (b == MINV) ? MAXV : -b;
  assign mul_ok = (&sprod[2*W-1:W-1]) | ~(|sprod[2*W-1:W-1]);

  function automatic logic [W-1:0] sat_w1(input logic [W:0] x);
    if (x[W] != x[W-1]) return x[W] ? MINV : MAXV;
    else                return x[W-1:0];
  endfunction

  always_comb begin
    bad = 1'b0;
    res = '0;
    unique case (op)
      OP_AND:  res = a & b;
      OP_NOR:  res = ~(a | b);
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << sh;
      OP_SRL:  res = a >> sh;
      OP_SRA:  res = sa >>> sh;
      OP_ADD:  res = sat_w1(ssum);
      OP_SUB:  res = sat_w1(sdiff);
      OP_MIN:  res = (sa < sb) ? a : b;
      OP_MAX:  res = (sa > sb) ? a : b;
      OP_MUL:  res = mul_ok ? sprod[W-1:0] : (sprod[2*W-1] ? MINV : MAXV);
      OP_MSGN: res = sa[W-1] ? neg_b : ((a == '0) ? '0 : b);
      default: begin
        bad = 1'b1;
        res = '0;
      end
    endcase
  end

  // R9: sign-transfer from a negative lane never yields the most negative value
  always_comb begin
    if (op == OP_MSGN && sa[W-1]) begin
      p_msgn_no_min_r9: assert (res != MINV);
    end
  end

  // R7: two non-negative addends never give a negative sum
  always_comb begin
    if (op == OP_ADD && !sa[W-1] && !sb[W-1]) begin
      p_add_pos_r7: assert (!res[W-1]);
    end
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  parameter int IMM_W  = 5,
  localparam int BLANES = DATA_W / BYTE_W,
  localparam int HLANES = DATA_W / HALF_W,
  localparam int BIDX_W = $clog2(BLANES),
  localparam int HIDX_W = $clog2(HLANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [4:0]        fmt_sel,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] vec_a,
  input  logic [DATA_W-1:0] vec_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  src_mode_e          mode;
  logic               fmt_half;
  logic [DATA_W-1:0]  opnd_byte, opnd_half;
  logic [DATA_W-1:0]  res_byte, res_half, res_sel;
  logic [BLANES-1:0]  bad_byte;
  logic [HLANES-1:0]  bad_half;
  logic               bad_sel;

  assign mode     = decode_src(fmt_sel[4:3]);
  assign fmt_half = fmt_sel[0];

  simd_opnd_sel #(.DATA_W(DATA_W), .LANE_W(BYTE_W), .IMM_W(IMM_W)) u_sel_byte (
    .mode (mode),
    .idx  (fmt_sel[3 -: BIDX_W]),
    .vec  (vec_b),
    .imm  (imm),
    .opnd (opnd_byte)
  );

  simd_opnd_sel #(.DATA_W(DATA_W), .LANE_W(HALF_W), .IMM_W(IMM_W)) u_sel_half (
    .mode (mode),
    .idx  (fmt_sel[3 -: HIDX_W]),
    .vec  (vec_b),
    .imm  (imm),
    .opnd (opnd_half)
  );

  for (genvar g = 0; g < BLANES; g++) begin : g_byte
    simd_byte_lane #(.W(BYTE_W)) u_lane (
      .op  (opcode),
      .a   (vec_a[g*BYTE_W +: BYTE_W]),
      .b   (opnd_byte[g*BYTE_W +: BYTE_W]),
      .res (res_byte[g*BYTE_W +: BYTE_W]),
      .bad (bad_byte[g])
    );
  end

  for (genvar g = 0; g < HLANES; g++) begin : g_half
    simd_half_lane #(.W(HALF_W)) u_lane (
      .op  (opcode),
      .a   (vec_a[g*HALF_W +: HALF_W]),
      .b   (opnd_half[g*HALF_W +: HALF_W]),
      .res (res_half[g*HALF_W +: HALF_W]),
      .bad (bad_half[g])
    );
  end

  assign res_sel = fmt_half ? res_half : res_byte;
  assign bad_sel = fmt_half ? (|bad_half) : (|bad_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & bad_sel;
      if (in_valid) begin
        result <= bad_sel ? '0 : res_sel;
      end
    end
  end

  // R2: each accepted request yields exactly one valid result a cycle later
  p_valid_lag_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R11: an illegal result is zero and only ever accompanies a valid result
  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0));
  p_illegal_valid_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);

endmodule

// File: tb/simd_lane_alu_test.sv
module simd_lane_alu_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  fmt_sel = '0;
  logic [3:0]  opcode = '0;
  logic [63:0] vec_a = '0;
  logic [63:0] vec_b = '0;
  logic [4:0]  imm = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .opcode(opcode), .vec_a(vec_a), .vec_b(vec_b), .imm(imm),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Independent model built from the requirements
  function automatic logic [63:0] model(input logic [4:0] fs, input logic [3:0] op,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [4:0] im, output logic bad);
    logic [63:0] r;
    r = '0;
    bad = 1'b0;
    if (!fs[0]) begin
      if (op == 4'd11 || op == 4'd12 || op == 4'd15) bad = 1'b1;
      for (int i = 0; i < 8; i++) begin
        int x, y, v;
        x = int'(a[i*8 +: 8]);
        if (!fs[4])      y = int'(b[int'(fs[3:1])*8 +: 8]);
        else if (!fs[3]) y = int'(b[i*8 +: 8]);
        else             y = int'(im);
        case (op)
          4'd0:  v = x & y;
          4'd1:  v = ~(x | y) & 255;
          4'd2:  v = x | y;
          4'd3:  v = x ^ y;
          4'd4:  v = (x << (y % 8)) & 255;
          4'd5:  v = x >> (y % 8);
          4'd6:  v = (x + y > 255) ? 255 : x + y;
          4'd7:  v = (x - y < 0) ? 0 : x - y;
          4'd8:  v = (x < y) ? x : y;
          4'd9:  v = (x > y) ? x : y;
          4'd10: v = (x * y > 255) ? 255 : x * y;
          4'd13: v = (x > y) ? x - y : y - x;
          4'd14: v = (x + y + 1) / 2;
          default: v = 0;
        endcase
        if (bad) v = 0;
        r[i*8 +: 8] = v[7:0];
      end
    end else begin
      if (op == 4'd13 || op == 4'd14 || op == 4'd15) bad = 1'b1;
      for (int i = 0; i < 4; i++) begin
        int x, y, v, s;
        x = int'($signed(a[i*16 +: 16]));
        if (!fs[4])      y = int'($signed(b[int'(fs[3:2])*16 +: 16]));
        else if (!fs[3]) y = int'($signed(b[i*16 +: 16]));
        else             y = int'(im);
        s = y & 15;
        case (op)
          4'd0:  v = x & y;
          4'd1:  v = ~(x | y);
          4'd2:  v = x | y;
          4'd3:  v = x ^ y;
          4'd4:  v = (x << s) & 16'hFFFF;
          4'd5:  v = (x & 16'hFFFF) >> s;
          4'd6:  v = sat16(x + y);
          4'd7:  v = sat16(x - y);
          4'd8:  v = (x < y) ? x : y;
          4'd9:  v = (x > y) ? x : y;
          4'd10: v = sat16(x * y);
          4'd11: v = (x < 0) ? ((y == -32768) ? 32767 : -y) : ((x == 0) ? 0 : y);
          4'd12: v = x >>> s;
          default: v = 0;
        endcase
        if (bad) v = 0;
        r[i*16 +: 16] = v[15:0];
      end
    end
    return r;
  endfunction

  // Present one request, then check the result one clock later
  task automatic run(input logic [4:0] fs, input logic [3:0] op, input logic [63:0] a,
                     input logic [63:0] b, input logic [4:0] im,
                     input logic [63:0] exp, input logic exp_ill, input string tag);
    @(negedge clk);
    fmt_sel = fs; opcode = op; vec_a = a; vec_b = b; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk(result === exp, tag, result, exp);
    chk(illegal === exp_ill, {tag, " illegal"}, {63'd0, illegal}, {63'd0, exp_ill});
  endtask

  task automatic run_model(input logic [4:0] fs, input logic [3:0] op, input logic [63:0] a,
                           input logic [63:0] b, input logic [4:0] im, input string tag);
    logic [63:0] e;
    logic eb;
    e = model(fs, op, a, b, im, eb);
    run(fs, op, a, b, im, e, eb, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid === 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk(result === 64'd0, "R1 result", result, 64'd0);
    chk(illegal === 1'b0, "R1 illegal", {63'd0, illegal}, 64'd0);
    rst = 1'b0;

    // R4 logic ops, full vector, bytes and halves
    run(5'b10000, 4'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 5'd0, 64'hF000_F000_F000_F000, 1'b0, "R4 and");
    run(5'b10001, 4'd1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 5'd0, 64'h000F_000F_000F_000F, 1'b0, "R4 nor");
    run(5'b10000, 4'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 5'd0, 64'hFFF0_FFF0_FFF0_FFF0, 1'b0, "R4 or");
    run(5'b10001, 4'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 5'd0, 64'h0FF0_0FF0_0FF0_0FF0, 1'b0, "R4 xor");

    // R5 shifts: masked counts, sign fill
    run(5'b11000, 4'd4, {8{8'h81}}, 64'd0, 5'd9, {8{8'h02}}, 1'b0, "R5 byte sll count masked");
    run(5'b10001, 4'd12, {4{16'h8000}}, {4{16'h0004}}, 5'd0, {4{16'hF800}}, 1'b0, "R5 half sra");
    run(5'b10001, 4'd5, {4{16'h8000}}, {4{16'h0004}}, 5'd0, {4{16'h0800}}, 1'b0, "R5 half srl");
    run(5'b10001, 4'd4, {4{16'h8001}}, {4{16'h0013}}, 5'd0, {4{16'h0008}}, 1'b0, "R5 half sll count masked");

    // R6 byte saturation
    run(5'b10000, 4'd6, {8{8'd200}}, {8{8'd100}}, 5'd0, {8{8'hFF}}, 1'b0, "R6 byte add clamp");
    run(5'b10000, 4'd7, {8{8'd5}}, {8{8'd10}}, 5'd0, 64'd0, 1'b0, "R6 byte sub floor");
    run(5'b10000, 4'd10, {{4{8'd16}}, {4{8'd3}}}, {{4{8'd16}}, {4{8'd7}}}, 5'd0,
        {{4{8'hFF}}, {4{8'h15}}}, 1'b0, "R6 byte mul clamp");

    // R7 halfword saturation
    run(5'b10001, 4'd6, {4{16'd30000}}, {4{16'd10000}}, 5'd0, {4{16'h7FFF}}, 1'b0, "R7 half add high");
    run(5'b10001, 4'd6, {4{16'h8AD0}}, {4{16'hD8F0}}, 5'd0, {4{16'h8000}}, 1'b0, "R7 half add low");
    run(5'b10001, 4'd10, {{2{16'h012C}}, {2{16'hFED4}}}, {4{16'h012C}}, 5'd0,
        {{2{16'h7FFF}}, {2{16'h8000}}}, 1'b0, "R7 half mul clamp");
    run(5'b10001, 4'd7, {4{16'h8000}}, {4{16'h0001}}, 5'd0, {4{16'h8000}}, 1'b0, "R7 half sub low");

    // R8 compare signedness
    run(5'b10000, 4'd9, {8{8'h80}}, {8{8'h7F}}, 5'd0, {8{8'h80}}, 1'b0, "R8 byte max unsigned");
    run(5'b10001, 4'd9, {4{16'h8080}}, {4{16'h7F7F}}, 5'd0, {4{16'h7F7F}}, 1'b0, "R8 half max signed");
    run(5'b10001, 4'd8, {4{16'h8080}}, {4{16'h7F7F}}, 5'd0, {4{16'h8080}}, 1'b0, "R8 half min signed");

    // R9 sign transfer
    run(5'b10001, 4'd11, 64'hFFFF_0000_0005_FFFD, 64'h8000_1234_FFF9_0009, 5'd0,
        64'h7FFF_0000_FFF9_FFF7, 1'b0, "R9 msgn");

    // R10 average and absolute difference
    run(5'b10000, 4'd14, 64'hFF00_1001_0000_0000, 64'hFF01_1302_0000_0000, 5'd0,
        64'hFF01_1202_0000_0000, 1'b0, "R10 avg");
    run(5'b10000, 4'd13, {8{8'd3}}, {8{8'd250}}, 5'd0, {8{8'd247}}, 1'b0, "R10 absdiff");

    // R3 operand source and lane index
    run(5'b01010, 4'd6, 64'd0, 64'h0807_0605_0403_0201, 5'd0, {8{8'h06}}, 1'b0, "R3 byte lane broadcast");
    run(5'b01101, 4'd2, 64'd0, 64'h4444_3333_2222_1111, 5'd0, {4{16'h4444}}, 1'b0, "R3 half lane broadcast");
    run(5'b11001, 4'd6, {4{16'd1}}, 64'hFFFF_FFFF_FFFF_FFFF, 5'h1F, {4{16'h0020}}, 1'b0, "R3 half immediate");

    // R11 illegal ops, then flag drops and result holds (R2)
    run(5'b10000, 4'd11, {8{8'h55}}, {8{8'h11}}, 5'd0, 64'd0, 1'b1, "R11 byte msgn");
    run(5'b10001, 4'd13, {4{16'h1234}}, {4{16'h0001}}, 5'd0, 64'd0, 1'b1, "R11 half absdiff");
    run(5'b10000, 4'd6, {8{8'h01}}, {8{8'h01}}, 5'd0, {8{8'h02}}, 1'b0, "R2 result before idle");
    held = result;
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk(result === held, "R2 idle hold", result, held);
    run(5'b11000, 4'd15, {8{8'hAA}}, 64'd0, 5'd3, 64'd0, 1'b1, "R11 reserved op");
    @(negedge clk);
    chk(illegal === 1'b0, "R11 flag one cycle", {63'd0, illegal}, 64'd0);

    // Random mix against the model (R3-R11)
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] fs;
      logic [3:0] op;
      logic [63:0] a, b;
      logic [4:0] im;
      fs = 5'($urandom);
      op = 4'($urandom);
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      im = 5'($urandom);
      run_model(fs, op, a, b, im, "R3-R11 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule